// File: doc/BRIEF.md
# RAID P/Q Parity Accumulation Datapath

This block forms the two parity results of a dual-parity disk array over a set of equally sized input buffers. Input data arrives as 64-bit beats. For every 8-byte offset of the buffers, the beats of all input buffers are presented in turn, each tagged with its buffer index and that buffer's controls: an enable for the plain parity, an enable for the weighted parity, and an 8-bit coefficient. The plain parity (P) is the XOR of the enabled buffers. The weighted parity (Q) is the XOR of each enabled byte multiplied in GF(2^8) by the buffer's coefficient. The reduction polynomial for the multiply is captured when a job starts.

After the last buffer of an offset has been taken, the block presents one output beat carrying both results, under a valid/ready handshake. A done flag marks the beat of the final offset. Either result can be cross-mixed with the other. Either pipe can instead run in compare mode. A pipe in compare mode delivers no data bytes and reports only the byte position of the first non-zero byte in its result stream.

Top module: `raid_pq_engine`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid`, `out_done` and `in_ready` are 0.
- R2: Each output beat's P field is the bitwise XOR of the beats, at that offset, of every buffer whose `in_p_en` is 1. Buffers with `in_p_en` 0 do not contribute.
- R3: Each byte lane of an output beat's Q field is the XOR, over buffers with `in_q_en` 1, of that lane's input byte times `in_coef` in GF(2^8). The reduction is modulo x^8 plus the 8-bit polynomial `cfg_poly`, where bit k of `cfg_poly` is the coefficient of x^k.
- R4: With every coefficient equal to 1 and identical P and Q enables, the Q field equals the P field.
- R5: With `cfg_mix_q` set, the Q field is the weighted result XORed with the plain result.
- R6: With `cfg_mix_p` set, the P field is the plain result XORed with the weighted result.
- R7: A pipe in compare mode (`cfg_cmp_p` or `cfg_cmp_q`) drives its data field to zero. On the done beat, its position output gives the lowest byte position holding a non-zero result byte (position = 8*offset + lane, with lane 0 at bits 7:0). If no such byte exists, the position is `cfg_size`.
- R8: Exactly one output beat is produced per offset. It appears after the buffer whose index equals `cfg_bufs`-1 has been taken. `out_done` is 1 only on the beat of offset `cfg_size`/8-1.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output fields hold steady and `in_ready` is 0.
- R10: `cfg_*` inputs are sampled only when a job starts. Changes to them during a job have no effect on its results.
- R11: `start` is honoured only when no job is running and no output beat is pending. Otherwise it is ignored.
- R12: Accumulation restarts on buffer index 0 of each offset. No value carries over between offsets or between jobs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a job, capturing the cfg_* inputs |
| cfg_bufs | input | 6 | Number of input buffers, 1 to 32 |
| cfg_size | input | 24 | Buffer length in bytes, a non-zero multiple of 8 |
| cfg_poly | input | 8 | Low 8 bits of the GF(2^8) reduction polynomial |
| cfg_mix_p | input | 1 | Fold the Q result into the P output |
| cfg_mix_q | input | 1 | Fold the P result into the Q output |
| cfg_cmp_p | input | 1 | P pipe in first-non-zero compare mode |
| cfg_cmp_q | input | 1 | Q pipe in first-non-zero compare mode |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | 64 | Input data beat |
| in_buf | input | 5 | Buffer index of the beat |
| in_p_en | input | 1 | Buffer takes part in P |
| in_q_en | input | 1 | Buffer takes part in Q |
| in_coef | input | 8 | Buffer's GF(2^8) coefficient for Q |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat taken when high with out_valid |
| out_p | output | 64 | P field of the output beat |
| out_q | output | 64 | Q field of the output beat |
| out_done | output | 1 | Output beat is the last of the job |
| out_p_pos | output | 24 | P compare position, meaningful on the done beat |
| out_q_pos | output | 24 | Q compare position, meaningful on the done beat |

## Verification
The hardest case to reach is the emission of an offset's result while the previous output beat is still stalled. At that moment the accumulator must be held and the input refused, not overwritten. The stimulus keeps a random consumer stalling `out_ready` about a quarter of the time, while the producer inserts random idle gaps. This makes the stall land on both middle and last buffers of an offset. Compare mode is driven toward its edges with directed jobs: one where every result byte is zero, so the sentinel appears, and one with a single non-zero byte deep inside the stream. A further job changes every configuration input and re-pulses start in mid-job, to show that neither reaches the results.

// File: rtl/raid_pq_pkg.sv
// Shared types for the P/Q parity datapath.
// Assumes nothing beyond being compiled before the modules that import it.
package raid_pq_pkg;

    localparam int BYTE_W = 8;

    // Output-shaping options of one job, captured at start.
    typedef struct packed {
        logic mix_p;   // P output also carries the Q result
        logic mix_q;   // Q output also carries the P result
        logic cmp_p;   // P pipe reports first non-zero position only
        logic cmp_q;   // Q pipe reports first non-zero position only
    } pq_mode_t;

endpackage

// File: rtl/raid_pq_gf_lane.sv
// One-byte GF(2^8) multiplier, purely combinational.
// Computes a*b modulo x^8 + poly, with poly holding the coefficients of x^7..x^0.
// Assumes: poly is stable for the duration of a job.
module raid_pq_gf_lane
    import raid_pq_pkg::*;
(
    input  logic [BYTE_W-1:0] a,
    input  logic [BYTE_W-1:0] b,
    input  logic [BYTE_W-1:0] poly,
    output logic [BYTE_W-1:0] prod
);

    // Shift-and-add multiply with reduction after every doubling.
    always_comb begin
        logic [BYTE_W-1:0] run;
        run  = a;
        prod = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) begin
                prod = prod ^ run;
            end
            run = {run[BYTE_W-2:0], 1'b0} ^ (run[BYTE_W-1] ? poly : '0);
        end
    end

endmodule

// File: rtl/raid_pq_nzfind.sv
// Finds the lowest byte lane of a word that is non-zero.
// Assumes lane 0 sits at the least significant byte.
module raid_pq_nzfind #(
    parameter int LANES  = 8,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic [LANES*8-1:0] word,
    output logic               found,
    output logic [LANE_W-1:0]  lane
);

    // Scan from the top lane down so the lowest non-zero lane wins.
    always_comb begin
        found = 1'b0;
        lane  = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (word[i*8 +: 8] != 8'h00) begin
                found = 1'b1;
                lane  = LANE_W'(i);
            end
        end
    end

endmodule

// File: rtl/raid_pq_accum.sv
// Per-offset accumulators of the plain (P) and weighted (Q) parity.
// sum_p / sum_q show the result including the beat currently offered;
// the registers take that value whenever a beat is accepted.
// Assumes: buffer index 0 is the first beat of every offset.
module raid_pq_accum
    import raid_pq_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int LANES = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              first,
    input  logic [DATA_W-1:0] in_data,
    input  logic              p_en,
    input  logic              q_en,
    input  logic [BYTE_W-1:0] coef,
    input  logic [BYTE_W-1:0] poly,
    output logic [DATA_W-1:0] sum_p,
    output logic [DATA_W-1:0] sum_q
);

    logic [DATA_W-1:0] acc_p;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] prod;

    // One GF multiplier per byte lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        raid_pq_gf_lane u_mul (
            .a    (in_data[g*BYTE_W +: BYTE_W]),
            .b    (coef),
            .poly (poly),
            .prod (prod[g*BYTE_W +: BYTE_W])
        );
    end

    // Fold the offered beat into the running sums; index 0 starts afresh.
    always_comb begin
        sum_p = (first ? '0 : acc_p) ^ (p_en ? in_data : '0);
        sum_q = (first ? '0 : acc_q) ^ (q_en ? prod : '0);
    end

    // Keep the running sums of the current offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_p <= '0;
            acc_q <= '0;
        end else if (take) begin
            acc_p <= sum_p;
            acc_q <= sum_q;
        end
    end

endmodule

// File: rtl/raid_pq_ctrl.sv
// Job sequencing and output register for the P/Q datapath.
// Captures the job settings on start, counts offsets, decides when an
// offset is complete, and holds one output beat under valid/ready.
// Assumes: beats of one offset arrive in buffer order 0..bufs-1.
module raid_pq_ctrl
    import raid_pq_pkg::*;
#(
    parameter int SIZE_W = 24,
    parameter int IDX_W  = 5,
    parameter int LANE_W = 3,
    parameter int PAY_W  = 128,
    localparam int CNT_W  = IDX_W + 1,
    localparam int BEAT_W = SIZE_W - LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  cfg_bufs,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [BYTE_W-1:0] cfg_poly,
    input  pq_mode_t          cfg_mode,
    input  logic              in_valid,
    input  logic [IDX_W-1:0]  in_buf,
    input  logic              out_ready,
    input  logic [PAY_W-1:0]  payload,
    output logic              in_ready,
    output logic              take,
    output logic              first_buf,
    output logic              emit,
    output logic              launch,
    output logic              busy,
    output logic [SIZE_W-1:0] lat_size,
    output logic [BYTE_W-1:0] lat_poly,
    output pq_mode_t          lat_mode,
    output logic [BEAT_W-1:0] beat_idx,
    output logic              out_valid,
    output logic [PAY_W-1:0]  out_payload,
    output logic              out_done
);

    logic [CNT_W-1:0]  lat_bufs;
    logic [BEAT_W-1:0] beats;
    logic              last_buf;
    logic              last_beat;

    // Handshake and offset-boundary decode.
    always_comb begin
        beats     = lat_size[SIZE_W-1:LANE_W];
        launch    = start && !busy && !out_valid;
        in_ready  = busy && (!out_valid || out_ready);
        take      = in_valid && in_ready;
        first_buf = (in_buf == '0);
        last_buf  = ({1'b0, in_buf} == lat_bufs - CNT_W'(1));
        last_beat = (beat_idx == beats - BEAT_W'(1));
        emit      = take && last_buf;
    end

    // Capture the job settings when a job is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_bufs <= '0;
            lat_size <= '0;
            lat_poly <= '0;
            lat_mode <= '0;
        end else if (launch) begin
            lat_bufs <= cfg_bufs;
            lat_size <= cfg_size;
            lat_poly <= cfg_poly;
            lat_mode <= cfg_mode;
        end
    end

    // Track the running job and the offset being accumulated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            beat_idx <= '0;
        end else if (launch) begin
            busy     <= 1'b1;
            beat_idx <= '0;
        end else if (emit) begin
            beat_idx <= beat_idx + BEAT_W'(1);
            if (last_beat) begin
                busy <= 1'b0;
            end
        end
    end

    // Output register: load on a completed offset, clear when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_done    <= 1'b0;
            out_payload <= '0;
        end else if (emit) begin
            out_valid   <= 1'b1;
            out_done    <= last_beat;
            out_payload <= payload;
        end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
            out_done  <= 1'b0;
        end
    end

endmodule

// File: rtl/raid_pq_engine.sv
// Top of the P/Q parity datapath.
// Accumulates P (XOR) and Q (GF(2^8) weighted XOR) per 8-byte offset over
// all input buffers, applies optional cross-mixing, and either passes the
// results out or, per pipe, tracks the first non-zero byte position.
// Assumes: cfg_size is a non-zero multiple of 8, 1 <= cfg_bufs <= MAX_BUFS.
module raid_pq_engine
    import raid_pq_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int MAX_BUFS = 32,
    parameter int SIZE_W   = 24,
    localparam int LANES  = DATA_W / BYTE_W,
    localparam int LANE_W = $clog2(LANES),
    localparam int IDX_W  = $clog2(MAX_BUFS),
    localparam int CNT_W  = IDX_W + 1,
    localparam int BEAT_W = SIZE_W - LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  cfg_bufs,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [7:0]        cfg_poly,
    input  logic              cfg_mix_p,
    input  logic              cfg_mix_q,
    input  logic              cfg_cmp_p,
    input  logic              cfg_cmp_q,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [IDX_W-1:0]  in_buf,
    input  logic              in_p_en,
    input  logic              in_q_en,
    input  logic [7:0]        in_coef,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_p,
    output logic [DATA_W-1:0] out_q,
    output logic              out_done,
    output logic [SIZE_W-1:0] out_p_pos,
    output logic [SIZE_W-1:0] out_q_pos
);

    pq_mode_t            cfg_mode;
    pq_mode_t            lat_mode;
    logic [SIZE_W-1:0]   lat_size;
    logic [BYTE_W-1:0]   lat_poly;
    logic [BEAT_W-1:0]   beat_idx;
    logic                take, first_buf, emit, launch, busy;
    logic [DATA_W-1:0]   sum_p, sum_q;
    logic [DATA_W-1:0]   raw_p, raw_q;
    logic [2*DATA_W-1:0] payload, out_payload;
    logic                nz_p, nz_q;
    logic [LANE_W-1:0]   lane_p, lane_q;
    logic                seen_p, seen_q;

    // Gather the mode inputs into one record.
    always_comb begin
        cfg_mode = '{mix_p: cfg_mix_p, mix_q: cfg_mix_q,
                     cmp_p: cfg_cmp_p, cmp_q: cfg_cmp_q};
    end

    raid_pq_ctrl #(
        .SIZE_W (SIZE_W),
        .IDX_W  (IDX_W),
        .LANE_W (LANE_W),
        .PAY_W  (2*DATA_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cfg_bufs    (cfg_bufs),
        .cfg_size    (cfg_size),
        .cfg_poly    (cfg_poly),
        .cfg_mode    (cfg_mode),
        .in_valid    (in_valid),
        .in_buf      (in_buf),
        .out_ready   (out_ready),
        .payload     (payload),
        .in_ready    (in_ready),
        .take        (take),
        .first_buf   (first_buf),
        .emit        (emit),
        .launch      (launch),
        .busy        (busy),
        .lat_size    (lat_size),
        .lat_poly    (lat_poly),
        .lat_mode    (lat_mode),
        .beat_idx    (beat_idx),
        .out_valid   (out_valid),
        .out_payload (out_payload),
        .out_done    (out_done)
    );

    raid_pq_accum #(
        .DATA_W (DATA_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .first   (first_buf),
        .in_data (in_data),
        .p_en    (in_p_en),
        .q_en    (in_q_en),
        .coef    (in_coef),
        .poly    (lat_poly),
        .sum_p   (sum_p),
        .sum_q   (sum_q)
    );

    // Cross-mix the pipe results and blank pipes that are in compare mode.
    always_comb begin
        raw_p   = lat_mode.mix_p ? (sum_p ^ sum_q) : sum_p;
        raw_q   = lat_mode.mix_q ? (sum_q ^ sum_p) : sum_q;
        payload = {(lat_mode.cmp_q ? '0 : raw_q), (lat_mode.cmp_p ? '0 : raw_p)};
    end

    raid_pq_nzfind #(.LANES(LANES)) u_nz_p (
        .word  (raw_p),
        .found (nz_p),
        .lane  (lane_p)
    );

    raid_pq_nzfind #(.LANES(LANES)) u_nz_q (
        .word  (raw_q),
        .found (nz_q),
        .lane  (lane_q)
    );

    // Record the first non-zero byte position of each pipe; sentinel is the size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_p_pos <= '0;
            out_q_pos <= '0;
            seen_p    <= 1'b0;
            seen_q    <= 1'b0;
        end else if (launch) begin
            out_p_pos <= cfg_size;
            out_q_pos <= cfg_size;
            seen_p    <= 1'b0;
            seen_q    <= 1'b0;
        end else if (emit) begin
            if (!seen_p && nz_p) begin
                out_p_pos <= {beat_idx, lane_p};
                seen_p    <= 1'b1;
            end
            if (!seen_q && nz_q) begin
                out_q_pos <= {beat_idx, lane_q};
                seen_q    <= 1'b1;
            end
        end
    end

    assign out_p = out_payload[DATA_W-1:0];
    assign out_q = out_payload[2*DATA_W-1:DATA_W];

endmodule

// File: rtl/raid_pq_checker.sv
// Property checker for raid_pq_engine, attached by bind below.
// Assumes it sees the top's ports plus the latched job settings.
module raid_pq_checker #(
    parameter int DATA_W = 64,
    parameter int SIZE_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_done,
    input logic [DATA_W-1:0] out_p,
    input logic [DATA_W-1:0] out_q,
    input logic [SIZE_W-1:0] out_p_pos,
    input logic [SIZE_W-1:0] out_q_pos,
    input logic [SIZE_W-1:0] lat_size,
    input logic              lat_cmp_p,
    input logic              lat_cmp_q
);

    // R1: idle on the first cycle after reset.
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!out_valid && !out_done && !in_ready));

    // R9: a stalled output beat holds its contents.
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_p) && $stable(out_q) && $stable(out_done)));

    // R9: no input is taken while the output is stalled.
    assert_stall_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R8: done only qualifies a valid beat.
    assert_done_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> out_valid);

    // R7: compare-mode pipes send no data bytes.
    assert_cmp_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((!lat_cmp_p || out_p == '0) && (!lat_cmp_q || out_q == '0)));

    // R7: reported positions never exceed the sentinel.
    assert_pos_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_done) |-> (out_p_pos <= lat_size && out_q_pos <= lat_size));

    // R11: a start during a job leaves the captured size alone.
    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(lat_size));

endmodule

bind raid_pq_engine raid_pq_checker #(
    .DATA_W (DATA_W),
    .SIZE_W (SIZE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_done  (out_done),
    .out_p     (out_p),
    .out_q     (out_q),
    .out_p_pos (out_p_pos),
    .out_q_pos (out_q_pos),
    .lat_size  (lat_size),
    .lat_cmp_p (lat_mode.cmp_p),
    .lat_cmp_q (lat_mode.cmp_q)
);

// File: tb/tb_raid_pq_engine.sv
`timescale 1ns/1ps
module tb_raid_pq_engine;

    localparam int DW = 64;
    localparam int SW = 24;
    localparam int CW = 6;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [CW-1:0] cfg_bufs;
    logic [SW-1:0] cfg_size;
    logic [7:0]    cfg_poly;
    logic          cfg_mix_p, cfg_mix_q, cfg_cmp_p, cfg_cmp_q;
    logic          in_valid, in_ready;
    logic [DW-1:0] in_data;
    logic [IW-1:0] in_buf;
    logic          in_p_en, in_q_en;
    logic [7:0]    in_coef;
    logic          out_valid, out_ready, out_done;
    logic [DW-1:0] out_p, out_q;
    logic [SW-1:0] out_p_pos, out_q_pos;

    always #2.5 clk = ~clk;

    raid_pq_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_bufs(cfg_bufs), .cfg_size(cfg_size), .cfg_poly(cfg_poly),
        .cfg_mix_p(cfg_mix_p), .cfg_mix_q(cfg_mix_q),
        .cfg_cmp_p(cfg_cmp_p), .cfg_cmp_q(cfg_cmp_q),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_buf(in_buf), .in_p_en(in_p_en), .in_q_en(in_q_en), .in_coef(in_coef),
        .out_valid(out_valid), .out_ready(out_ready), .out_p(out_p), .out_q(out_q),
        .out_done(out_done), .out_p_pos(out_p_pos), .out_q_pos(out_q_pos)
    );

    int checks = 0;
    int errors = 0;

    // Job description
    logic [63:0] dat [32][16];
    logic        pe [32];
    logic        qe [32];
    logic [7:0]  cf [32];
    int          j_nb, j_beats;
    logic [7:0]  j_poly;
    logic        j_xp, j_xq, j_cp, j_cq;
    string       j_req;
    logic        j_disturb;
    logic        bp_on;

    logic [63:0] ep [$];
    logic [63:0] eq [$];
    int          epos_p, epos_q;
    int          rcv;

    // Reference GF(2^8) product: carry-less multiply, then long-division reduce.
    function automatic logic [7:0] gf_ref(input logic [7:0] a, input logic [7:0] b,
                                          input logic [7:0] poly);
        logic [14:0] t;
        t = '0;
        for (int i = 0; i < 8; i++) if (b[i]) t = t ^ (15'(a) << i);
        for (int k = 14; k >= 8; k--) if (t[k]) t = t ^ (15'({1'b1, poly}) << (k - 8));
        return t[7:0];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Build the expected output beats and positions for the current job.
    task automatic compute_expected();
        bit fp, fq;
        ep.delete();
        eq.delete();
        epos_p = j_beats * 8;
        epos_q = j_beats * 8;
        fp = 0;
        fq = 0;
        for (int b = 0; b < j_beats; b++) begin
            logic [63:0] p, q, rp, rq;
            p = '0;
            q = '0;
            for (int i = 0; i < j_nb; i++) begin
                if (pe[i]) p = p ^ dat[i][b];
                if (qe[i])
                    for (int l = 0; l < 8; l++)
                        q[l*8 +: 8] = q[l*8 +: 8] ^ gf_ref(dat[i][b][l*8 +: 8], cf[i], j_poly);
            end
            rp = j_xp ? (p ^ q) : p;
            rq = j_xq ? (q ^ p) : q;
            for (int l = 0; l < 8; l++) begin
                if (!fp && rp[l*8 +: 8] != 0) begin fp = 1; epos_p = b*8 + l; end
                if (!fq && rq[l*8 +: 8] != 0) begin fq = 1; epos_q = b*8 + l; end
            end
            ep.push_back(j_cp ? 64'h0 : rp);
            eq.push_back(j_cq ? 64'h0 : rq);
        end
    endtask

    task automatic fill_random(input int nb, input int beats);
        j_nb = nb;
        j_beats = beats;
        for (int i = 0; i < nb; i++) begin
            pe[i] = 1'($urandom % 2);
            qe[i] = 1'($urandom % 2);
            cf[i] = 8'($urandom);
            for (int b = 0; b < beats; b++) dat[i][b] = {$urandom, $urandom};
        end
        pe[0] = 1'b1;
        qe[0] = 1'b1;
        j_xp = 0; j_xq = 0; j_cp = 0; j_cq = 0;
        j_poly = 8'h1d;
        j_disturb = 0;
    endtask

    // Run one job: start, feed beats offset-major, wait for every output beat.
    task automatic run_job();
        compute_expected();
        rcv = 0;
        @(negedge clk);
        start = 1'b1;
        cfg_bufs = CW'(j_nb);
        cfg_size = SW'(j_beats * 8);
        cfg_poly = j_poly;
        cfg_mix_p = j_xp; cfg_mix_q = j_xq; cfg_cmp_p = j_cp; cfg_cmp_q = j_cq;
        @(negedge clk);
        start = 1'b0;
        if (j_disturb) begin
            // R10 / R11: change every setting and re-pulse start mid-job
            start = 1'b1;
            cfg_bufs = CW'(j_nb + 1);
            cfg_size = SW'(j_beats * 8 + 16);
            cfg_poly = ~j_poly;
            cfg_mix_p = ~j_xp; cfg_mix_q = ~j_xq; cfg_cmp_p = ~j_cp; cfg_cmp_q = ~j_cq;
            @(negedge clk);
            start = 1'b0;
        end
        for (int b = 0; b < j_beats; b++) begin
            for (int i = 0; i < j_nb; i++) begin
                int gap;
                gap = $urandom % 3;
                for (int g = 0; g < gap; g++) begin
                    in_valid = 1'b0;
                    @(negedge clk);
                end
                in_valid = 1'b1;
                in_data  = dat[i][b];
                in_buf   = IW'(i);
                in_p_en  = pe[i];
                in_q_en  = qe[i];
                in_coef  = cf[i];
                #1;
                while (!in_ready) begin
                    @(negedge clk);
                    #1;
                end
                @(posedge clk);
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        while (rcv < j_beats) @(negedge clk);
        @(negedge clk);
    endtask

    // Output consumer with random stalls; checks every beat it takes.
    logic          held;
    logic [63:0]   h_p, h_q;
    logic          h_d;
    initial held = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            logic r;
            if (held) begin
                check(out_valid && out_p == h_p && out_q == h_q && out_done == h_d,
                      "R9", "stalled beat changed", out_p, h_p);
                held = 1'b0;
            end
            r = bp_on ? (($urandom % 4) != 0) : 1'b1;
            out_ready = r;
            if (out_valid && r) begin
                if (ep.size() == 0) begin
                    check(0, j_req, "unexpected output beat", out_p, 64'h0);
                end else begin
                    logic [63:0] xp, xq;
                    xp = ep.pop_front();
                    xq = eq.pop_front();
                    check(out_p == xp, j_req, "P field", out_p, xp);
                    check(out_q == xq, j_req, "Q field", out_q, xq);
                    check(out_done == (rcv == j_beats - 1), "R8", "done flag",
                          64'(out_done), 64'(rcv == j_beats - 1));
                    if (out_done) begin
                        check(out_p_pos == SW'(epos_p), "R7", "P position", 64'(out_p_pos), 64'(epos_p));
                        check(out_q_pos == SW'(epos_q), "R7", "Q position", 64'(out_q_pos), 64'(epos_q));
                    end
                end
                rcv++;
            end else if (out_valid) begin
                h_p = out_p;
                h_q = out_q;
                h_d = out_done;
                held = 1'b1;
                #1;
                check(!in_ready, "R9", "in_ready during stall", 64'(in_ready), 64'h0);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        rst_n = 1'b0;
        start = 1'b0;
        cfg_bufs = '0; cfg_size = '0; cfg_poly = '0;
        cfg_mix_p = 0; cfg_mix_q = 0; cfg_cmp_p = 0; cfg_cmp_q = 0;
        in_valid = 1'b0; in_data = '0; in_buf = '0;
        in_p_en = 0; in_q_en = 0; in_coef = '0;
        out_ready = 1'b1;
        bp_on = 1'b0;
        j_beats = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!out_valid && !out_done && !in_ready, "R1", "idle in reset",
              {61'h0, out_valid, out_done, in_ready}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !out_done && !in_ready, "R1", "idle after reset",
              {61'h0, out_valid, out_done, in_ready}, 64'h0);

        // R2 R3 R12: plain accumulation over several offsets
        j_req = "R2 R3 R12";
        fill_random(3, 4);
        run_job();

        // R4: unit coefficients make Q equal P
        j_req = "R4";
        fill_random(4, 3);
        for (int i = 0; i < 4; i++) begin cf[i] = 8'h01; qe[i] = pe[i]; end
        compute_expected();
        for (int b = 0; b < 3; b++) check(ep[b] == eq[b], "R4", "model P/Q", eq[b], ep[b]);
        run_job();

        // R5: Q folded with P
        j_req = "R5";
        fill_random(3, 3);
        j_xq = 1;
        run_job();

        // R6: P folded with Q, under backpressure
        j_req = "R6 R9";
        bp_on = 1'b1;
        fill_random(5, 3);
        j_xp = 1;
        j_poly = 8'h4d;
        run_job();

        // R7: all-zero result gives the size sentinel
        j_req = "R7";
        fill_random(3, 3);
        for (int i = 0; i < 3; i++) for (int b = 0; b < 3; b++) dat[i][b] = '0;
        j_cp = 1; j_cq = 1;
        run_job();

        // R7: single non-zero byte at offset 2, lane 5 -> position 21
        j_req = "R7";
        fill_random(3, 4);
        for (int i = 0; i < 3; i++) begin
            pe[i] = 1; qe[i] = 1; cf[i] = 8'h03;
            for (int b = 0; b < 4; b++) dat[i][b] = '0;
        end
        dat[1][2] = 64'h0000_5a00_0000_0000;
        j_cp = 1; j_cq = 1;
        compute_expected();
        check(epos_p == 21 && epos_q == 21, "R7", "model position", 64'(epos_p), 64'd21);
        run_job();

        // R8: maximum buffer count and single buffer
        j_req = "R8";
        fill_random(32, 2);
        run_job();
        fill_random(1, 5);
        run_job();

        // R10 R11: settings changed and start re-pulsed during a job
        j_req = "R10 R11";
        fill_random(4, 4);
        j_poly = 8'h2b;
        j_disturb = 1;
        run_job();

        // Random mix of all options
        for (int n = 0; n < 20; n++) begin
            j_req = "R2 R3 R5 R6 R7";
            fill_random(1 + ($urandom % 8), 1 + ($urandom % 8));
            j_poly = 8'($urandom);
            j_xp = 1'($urandom % 2);
            j_xq = 1'($urandom % 2);
            j_cp = 1'($urandom % 4 == 0);
            j_cq = 1'($urandom % 4 == 0);
            run_job();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule